// File: doc/BRIEF.md
# VF Non-Fatal Error Message Requester

This block sits in application logic beside a PCIe endpoint core that runs with SR-IOV. The core reports virtual-function errors on one or two parallel report slots. Each slot carries four separate error flags (a poisoned write request arrived, a poisoned completion arrived, a posted request was unsupported, or a posted request hit a completer abort) plus the 11-bit VF number and 3-bit PF number of the function that saw the error. The core has already logged the error status, so this block writes no status register. Its only job is to ask the core to send a non-fatal error message for each report.

Every slot that shows at least one flag in a cycle produces one entry, holding that slot's VF and PF, in a small local queue. A two-state machine takes entries from the queue and offers them on a set/ready handshake. In `ST_IDLE`, a non-empty queue causes the transition *load* to `ST_OFFER`, which pops the head into the output register. In `ST_OFFER`, the strobe is high with the numbers held. The transition *accept* back to `ST_IDLE` happens in the first cycle in which ready is seen high. If the local queue is full, new entries are dropped and counted. The core's overflow indication sets a sticky bit and is also counted.

Top module: `vf_err_msg_req`

## Requirements
- R1: A slot with any one or more of its four flags high in a cycle queues exactly one entry carrying that slot's VF and PF numbers. A slot with no flag high queues nothing.
- R2: When both slots queue an entry in the same cycle, the slot 0 entry is offered before the slot 1 entry.
- R3: While `msg_set` is high and `msg_ready` is low, `msg_set`, `msg_vf` and `msg_pf` keep their values into the next cycle.
- R4: An offer is accepted only in a cycle with `msg_set` and `msg_ready` both high. In the cycle after an acceptance, `msg_set` is low.
- R5: The queue holds `DEPTH` entries. This occupancy is counted at the start of the cycle, and a same-cycle pop does not free room. An entry that finds the queue full is discarded, and `drop_count` rises by one for each discarded entry, saturating at all ones.
- R6: `core_overflow` high in a cycle sets `lost_sticky` from the next cycle onward, and `lost_sticky` stays set until reset.
- R7: `core_lost_count` rises by one for each cycle in which `core_overflow` is high, saturating at all ones.
- R8: A synchronous active-high `rst` empties the queue, returns the state machine to `ST_IDLE`, and clears `msg_set`, both counters and `lost_sticky`.
- R9: With the queue empty and the machine in `ST_IDLE`, a flag in cycle N gives `msg_set` high in cycle N+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_poison_wr | input | NUM_SLOTS | Poisoned write request flag, one bit per slot |
| err_poison_cpl | input | NUM_SLOTS | Poisoned completion flag, one bit per slot |
| err_ur_posted | input | NUM_SLOTS | Posted unsupported-request flag, one bit per slot |
| err_ca_posted | input | NUM_SLOTS | Posted completer-abort flag, one bit per slot |
| err_vf | input | NUM_SLOTS*11 | VF numbers, slot 0 in the low 11 bits |
| err_pf | input | NUM_SLOTS*3 | PF numbers, slot 0 in the low 3 bits |
| core_overflow | input | 1 | Core dropped an error report |
| msg_set | output | 1 | Request to send a non-fatal error message |
| msg_vf | output | 11 | VF number of the request, valid with msg_set |
| msg_pf | output | 3 | PF number of the request, valid with msg_set |
| msg_ready | input | 1 | Core accepts the request in this cycle |
| lost_sticky | output | 1 | Core overflow has been seen since reset |
| drop_count | output | CNT_W | Saturating count of entries discarded on a full queue |
| core_lost_count | output | CNT_W | Saturating count of core overflow cycles |

## Verification
Queue filling and queue draining can happen in the same cycle. Pushes from both slots can meet a pop while the queue is one or two entries short of full. Whether the second slot's entry is kept or dropped then depends on occupancy at the start of the cycle. The bench provokes this by holding ready low until the queue fills, then toggling ready randomly while both slots keep firing. A queue-based reference model decides each push and each drop against the same start-of-cycle rule. Its predictions for strobe, numbers and drop count are compared with the outputs on every clock.

// File: rtl/vf_err_pkg.sv
package vf_err_pkg;

    localparam int VF_W = 11;
    localparam int PF_W = 3;

    typedef struct packed {
        logic [VF_W-1:0] vf;
        logic [PF_W-1:0] pf;
    } vf_err_entry_t;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } req_state_e;

endpackage

// File: rtl/vf_slot_capture.sv
module vf_slot_capture
    import vf_err_pkg::*;
#(
    parameter int NUM_SLOTS = 2
) (
    input  logic [NUM_SLOTS-1:0]      poison_wr,
    input  logic [NUM_SLOTS-1:0]      poison_cpl,
    input  logic [NUM_SLOTS-1:0]      ur_posted,
    input  logic [NUM_SLOTS-1:0]      ca_posted,
    input  logic [NUM_SLOTS*VF_W-1:0] vf_bus,
    input  logic [NUM_SLOTS*PF_W-1:0] pf_bus,
    output logic [NUM_SLOTS-1:0]      hit,
    output vf_err_entry_t [NUM_SLOTS-1:0] entry
);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        // R1: any of the four kinds yields one entry
        assign hit[s]      = poison_wr[s] | poison_cpl[s] | ur_posted[s] | ca_posted[s];
        assign entry[s].vf = vf_bus[s*VF_W +: VF_W];
        assign entry[s].pf = pf_bus[s*PF_W +: PF_W];
    end

endmodule

// File: rtl/vf_err_fifo.sv
module vf_err_fifo
    import vf_err_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int NPUSH = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int SW    = CW + 1,
    localparam int DW    = $clog2(NPUSH + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NPUSH-1:0]          push_valid,
    input  vf_err_entry_t [NPUSH-1:0] push_data,
    input  logic                      pop,
    output vf_err_entry_t             head,
    output logic                      empty,
    output logic [DW-1:0]             drop_num
);

    vf_err_entry_t    mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr, wr_ptr_d;
    logic [CW-1:0]    count, count_d;
    logic [NPUSH-1:0] we;
    logic [PTR_W-1:0] waddr [NPUSH];

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // R5: room judged on start-of-cycle occupancy, slot order gives priority (R2)
    always_comb begin
        logic [SW-1:0]    n_acc;
        logic [PTR_W-1:0] widx;
        n_acc    = '0;
        widx     = wr_ptr;
        drop_num = '0;
        for (int k = 0; k < NPUSH; k++) begin
            we[k]    = 1'b0;
            waddr[k] = widx;
            if (push_valid[k]) begin
                if (({1'b0, count} + n_acc) < SW'(DEPTH)) begin
                    we[k] = 1'b1;
                    widx  = nxt(widx);
                    n_acc = n_acc + SW'(1);
                end else begin
                    drop_num = drop_num + DW'(1);
                end
            end
        end
        wr_ptr_d = widx;
        count_d  = CW'({1'b0, count} + n_acc - SW'(pop));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr_d;
            count  <= count_d;
            if (pop) rd_ptr <= nxt(rd_ptr);
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NPUSH; k++) begin
            if (we[k]) mem[waddr[k]] <= push_data[k];
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);

endmodule

// File: rtl/vf_sat_counter.sv
module vf_sat_counter #(
    parameter int W  = 8,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] inc,
    output logic [W-1:0]  cnt
);

    logic [W:0] sum;
    assign sum = {1'b0, cnt} + (W+1)'(inc);

    always_ff @(posedge clk) begin
        if (rst)         cnt <= '0;
        else if (sum[W]) cnt <= '1;
        else             cnt <= sum[W-1:0];
    end

endmodule

// File: rtl/vf_err_msg_req.sv
module vf_err_msg_req
    import vf_err_pkg::*;
#(
    parameter int NUM_SLOTS = 2,
    parameter int DEPTH     = 8,
    parameter int CNT_W     = 8,
    localparam int DW       = $clog2(NUM_SLOTS + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_SLOTS-1:0]      err_poison_wr,
    input  logic [NUM_SLOTS-1:0]      err_poison_cpl,
    input  logic [NUM_SLOTS-1:0]      err_ur_posted,
    input  logic [NUM_SLOTS-1:0]      err_ca_posted,
    input  logic [NUM_SLOTS*11-1:0]   err_vf,
    input  logic [NUM_SLOTS*3-1:0]    err_pf,
    input  logic                      core_overflow,
    output logic                      msg_set,
    output logic [10:0]               msg_vf,
    output logic [2:0]                msg_pf,
    input  logic                      msg_ready,
    output logic                      lost_sticky,
    output logic [CNT_W-1:0]          drop_count,
    output logic [CNT_W-1:0]          core_lost_count
);

    logic [NUM_SLOTS-1:0]          slot_hit;
    vf_err_entry_t [NUM_SLOTS-1:0] slot_entry;
    vf_err_entry_t                 q_head, out_q;
    logic                          q_empty, q_pop;
    logic [DW-1:0]                 q_drop;
    req_state_e                    state_q, state_d;

    vf_slot_capture #(.NUM_SLOTS(NUM_SLOTS)) u_cap (
        .poison_wr (err_poison_wr),
        .poison_cpl(err_poison_cpl),
        .ur_posted (err_ur_posted),
        .ca_posted (err_ca_posted),
        .vf_bus    (err_vf),
        .pf_bus    (err_pf),
        .hit       (slot_hit),
        .entry     (slot_entry)
    );

    vf_err_fifo #(.DEPTH(DEPTH), .NPUSH(NUM_SLOTS)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push_valid(slot_hit),
        .push_data (slot_entry),
        .pop       (q_pop),
        .head      (q_head),
        .empty     (q_empty),
        .drop_num  (q_drop)
    );

    // R5: saturating count of locally discarded entries
    vf_sat_counter #(.W(CNT_W), .IW(DW)) u_drop_cnt (
        .clk(clk), .rst(rst), .inc(q_drop), .cnt(drop_count)
    );

    // R7: saturating count of core overflow cycles
    vf_sat_counter #(.W(CNT_W), .IW(1)) u_lost_cnt (
        .clk(clk), .rst(rst), .inc(core_overflow), .cnt(core_lost_count)
    );

    // next-state logic: load and accept transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!q_empty)  state_d = ST_OFFER;
            ST_OFFER: if (msg_ready) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    assign q_pop = (state_q == ST_IDLE) && !q_empty;

    // state register (R8)
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // output register: loaded only on the load transition, so held in ST_OFFER (R3)
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q       <= '0;
            lost_sticky <= 1'b0;
        end else begin
            if (q_pop)         out_q       <= q_head;
            if (core_overflow) lost_sticky <= 1'b1;   // R6
        end
    end

    assign msg_set = (state_q == ST_OFFER);
    assign msg_vf  = out_q.vf;
    assign msg_pf  = out_q.pf;

endmodule

// File: rtl/vf_err_msg_req_chk.sv
module vf_err_msg_req_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             msg_set,
    input logic             msg_ready,
    input logic [10:0]      msg_vf,
    input logic [2:0]       msg_pf,
    input logic             core_overflow,
    input logic             lost_sticky,
    input logic [CNT_W-1:0] drop_count,
    input logic [CNT_W-1:0] core_lost_count
);

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        msg_set && !msg_ready |=> msg_set && $stable(msg_vf) && $stable(msg_pf));

    p_gap_after_accept_r4: assert property (@(posedge clk) disable iff (rst)
        msg_set && msg_ready |=> !msg_set);

    p_drop_monotonic_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> drop_count >= $past(drop_count));

    p_overflow_flags_r6: assert property (@(posedge clk) disable iff (rst)
        core_overflow |=> lost_sticky);

    p_sticky_holds_r6: assert property (@(posedge clk) disable iff (rst)
        lost_sticky |=> lost_sticky);

    p_lost_monotonic_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> core_lost_count >= $past(core_lost_count));

    p_reset_clears_r8: assert property (@(posedge clk)
        rst |=> !msg_set && !lost_sticky && drop_count == '0 && core_lost_count == '0);

endmodule

bind vf_err_msg_req vf_err_msg_req_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .msg_set        (msg_set),
    .msg_ready      (msg_ready),
    .msg_vf         (msg_vf),
    .msg_pf         (msg_pf),
    .core_overflow  (core_overflow),
    .lost_sticky    (lost_sticky),
    .drop_count     (drop_count),
    .core_lost_count(core_lost_count)
);

// File: tb/vf_err_msg_req_tb.sv
module vf_err_msg_req_tb_top;

    localparam int NS    = 2;
    localparam int DEPTH = 8;
    localparam int CW    = 8;
    localparam int CMAX  = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] pw = '0, pc = '0, ur = '0, ca = '0;
    logic [NS*11-1:0] vf = '0;
    logic [NS*3-1:0]  pf = '0;
    logic          ovf = 1'b0;
    logic          rdy = 1'b0;
    logic          msg_set, lost_sticky;
    logic [10:0]   msg_vf;
    logic [2:0]    msg_pf;
    logic [CW-1:0] drop_count, core_lost_count;

    always #4 clk = ~clk;   // 125 MHz

    vf_err_msg_req #(.NUM_SLOTS(NS), .DEPTH(DEPTH), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst),
        .err_poison_wr(pw), .err_poison_cpl(pc), .err_ur_posted(ur), .err_ca_posted(ca),
        .err_vf(vf), .err_pf(pf), .core_overflow(ovf),
        .msg_set(msg_set), .msg_vf(msg_vf), .msg_pf(msg_pf), .msg_ready(rdy),
        .lost_sticky(lost_sticky), .drop_count(drop_count), .core_lost_count(core_lost_count)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // reference model
    int q_vf[$];
    int q_pf[$];
    bit m_offer = 0;
    int m_vf = 0, m_pf = 0, m_drop = 0, m_lost = 0;
    bit m_sticky = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            q_vf.delete(); q_pf.delete();
            m_offer = 0; m_drop = 0; m_lost = 0; m_sticky = 0;
        end else begin
            int start, acc;
            start = q_vf.size();
            if (m_offer) begin
                if (rdy) m_offer = 0;
            end else if (start > 0) begin
                m_vf = q_vf.pop_front();
                m_pf = q_pf.pop_front();
                m_offer = 1;
            end
            acc = 0;
            for (int s = 0; s < NS; s++) begin
                if (pw[s] | pc[s] | ur[s] | ca[s]) begin
                    if (start + acc < DEPTH) begin
                        q_vf.push_back(int'(vf[s*11 +: 11]));
                        q_pf.push_back(int'(pf[s*3 +: 3]));
                        acc++;
                    end else if (m_drop < CMAX) m_drop++;
                end
            end
            if (ovf) begin
                m_sticky = 1;
                if (m_lost < CMAX) m_lost++;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(msg_set == m_offer, "R4 msg_set", int'(msg_set), int'(m_offer));
            if (m_offer && msg_set) begin
                chk(int'(msg_vf) == m_vf, "R1 R2 msg_vf", int'(msg_vf), m_vf);
                chk(int'(msg_pf) == m_pf, "R1 R2 msg_pf", int'(msg_pf), m_pf);
            end
            chk(int'(drop_count) == m_drop, "R5 drop_count", int'(drop_count), m_drop);
            chk(lost_sticky == m_sticky, "R6 lost_sticky", int'(lost_sticky), int'(m_sticky));
            chk(int'(core_lost_count) == m_lost, "R7 core_lost_count", int'(core_lost_count), m_lost);
        end
    end

    task automatic report();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        wait (cycles > 150000);
        chk(1'b0, "watchdog", cycles, 150000);
        report();
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic clear_flags();
        pw = '0; pc = '0; ur = '0; ca = '0;
    endtask

    task automatic check_reset_state();
        @(negedge clk);
        chk(!msg_set && !lost_sticky && drop_count == 0 && core_lost_count == 0,
            "R8 reset state", int'({msg_set, lost_sticky}) + int'(drop_count) + int'(core_lost_count), 0);
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        check_reset_state();

        // R9: latency from flag to strobe, slot 0 poisoned write
        step();
        rdy = 1'b1;
        vf[10:0] = 11'd5; pf[2:0] = 3'd2; pw[0] = 1'b1;
        step(); clear_flags();
        @(negedge clk);
        chk(msg_set == 1'b0, "R9 strobe still low", int'(msg_set), 0);
        step();
        @(negedge clk);
        chk(msg_set == 1'b1 && msg_vf == 11'd5 && msg_pf == 3'd2, "R9 strobe at N+2",
            int'({msg_set, msg_vf, msg_pf}), int'({1'b1, 11'd5, 3'd2}));
        repeat (4) step();

        // R1 R2: each flag kind alone, both slots together, s0 before s1
        for (int k = 0; k < 4; k++) begin
            vf = {11'(100 + k), 11'(200 + k)};
            pf = {3'(k), 3'(7 - k)};
            case (k)
                0: pw = 2'b11;
                1: pc = 2'b11;
                2: ur = 2'b11;
                default: ca = 2'b11;
            endcase
            step(); clear_flags();
            repeat (6) step();
        end
        // no flag: nothing queued (R1)
        vf = {11'd1, 11'd2};
        repeat (6) step();

        // R3 R5: ready low, both slots flood the queue, drop counter saturates
        rdy = 1'b0;
        ovf = 1'b1;
        for (int c = 0; c < 300; c++) begin
            vf = {11'(c + 512), 11'(c)};
            pf = {3'(c), 3'(c + 1)};
            pw = {1'b0, 1'b1}; ca = {1'b1, 1'b0};
            step();
        end
        clear_flags();
        ovf = 1'b0;
        @(negedge clk);
        chk(drop_count == CW'(CMAX), "R5 drop saturation", int'(drop_count), CMAX);
        chk(core_lost_count == CW'(CMAX), "R7 lost saturation", int'(core_lost_count), CMAX);

        // drain and overlap fill with drain under random ready
        for (int c = 0; c < 3000; c++) begin
            rdy = ($urandom_range(0, 2) != 0);
            pw  = NS'($urandom_range(0, 3)) & NS'({NS{$urandom_range(0, 1) == 1}});
            ur  = NS'($urandom_range(0, 3)) & NS'({NS{$urandom_range(0, 3) == 0}});
            vf  = NS*11'($urandom());
            pf  = NS*3'($urandom());
            step();
        end
        clear_flags();

        // R8: reset in mid-run with entries pending
        rdy = 1'b0; pw = 2'b11; ovf = 1'b1;
        repeat (3) step();
        rst = 1'b1; clear_flags(); ovf = 1'b0;
        repeat (2) step();
        rst = 1'b0;
        check_reset_state();
        repeat (4) step();
        @(negedge clk);
        chk(msg_set == 1'b0, "R8 queue emptied by reset", int'(msg_set), 0);

        // R6: one overflow pulse sets the sticky bit, which stays set
        ovf = 1'b1; step(); ovf = 1'b0;
        repeat (10) step();
        @(negedge clk);
        chk(lost_sticky == 1'b1, "R6 sticky held", int'(lost_sticky), 1);

        for (int c = 0; c < 1000; c++) begin
            rdy = $urandom_range(0, 1) == 1;
            ca  = NS'($urandom_range(0, 3));
            pc  = NS'($urandom_range(0, 3)) & NS'({NS{$urandom_range(0, 1) == 1}});
            vf  = NS*11'($urandom());
            pf  = NS*3'($urandom());
            ovf = $urandom_range(0, 50) == 0;
            step();
        end
        clear_flags(); ovf = 1'b0; rdy = 1'b1;
        repeat (40) step();
        report();
    end

endmodule